// File: doc/BRIEF.md
# Stopwatch Datapath with Lap Hold

This block is the counting and display-selection half of a stopwatch that resolves tenths of a second. An external controller steers it through a single 6-bit control word and receives back one status bit, `tenth`, which is high while the internal prescaler sits at zero. The controller reacts to that bit by raising the digit-enable bit for one cycle. This advances a chain of four decimal digits by one tenth of a second.

A lap register can take a snapshot of the running digits. A selector then shows either the live digits or the snapshot on the display output. The display can therefore stay frozen on a lap time while the live count keeps advancing underneath. All state is cleared by an active-low synchronous reset.

Control word layout, most significant bit first: bit 5 selects the display source, bit 4 loads the lap register, bit 3 clears the digits, bit 2 enables the digits, and bits 1:0 give the prescaler mode. Display packing: bits 3:0 hold tenths, 7:4 hold seconds, 11:8 hold tens of seconds, and 15:12 hold minutes, each as a BCD digit.

Top module: `stopwatch_datapath`

## Requirements
- R1: When `rst_n` is low at a rising edge, the prescaler count, all digits and the lap register become zero. After that edge `tenth` is 1 and `disp` is 16'h0000 whichever source bit 5 selects.
- R2: With mode code 01 or 10 in bits 1:0, the prescaler decrements by one per cycle. From zero it wraps to RELOAD = CLK_HZ/10 - 1.
- R3: With mode code 00 the prescaler count holds, so `tenth` keeps its value.
- R4: With mode code 11 the prescaler is loaded with RELOAD, so `tenth` is 0 in the following cycle.
- R5: `tenth` is 1 exactly while the prescaler count is zero. Under continuous counting it is high for one cycle in every RELOAD+1.
- R6: With bit 2 set and bit 3 clear, the tenths digit advances by one at the edge and goes from 9 back to 0. With bits 2 and 3 both clear, the digits hold.
- R7: A higher digit advances only at an enabled edge where every lower digit is 9. Every digit, minutes included, wraps from 9 to 0, so 9:99.9 (16'h9999) is followed by 16'h0000.
- R8: With bit 3 set, all digits become zero at the edge, whatever the value of bit 2.
- R9: With bit 4 set, the lap register captures the digit value present before the edge. With bit 4 clear, the lap register holds.
- R10: Within the same cycle, `disp` shows the live digits when bit 5 is 0 and the lap register when bit 5 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl | input | 6 | Control word from the controller |
| tenth | output | 1 | High while the prescaler count is zero |
| disp | output | 16 | Selected four-digit BCD value |

## Verification
The hardest state to reach is the wrap of the minutes digit. It needs ten thousand enabled edges with no clear in between. The stimulus holds the enable bit for a directed burst that is long enough to pass 9:99.9 and return to zero, and it checks every intermediate value. Lap freezing with the count running underneath comes from a directed sequence that loads the lap register and then keeps counting with bit 5 set. A long mixed run of random control words, with occasional resets, then covers the interactions of clear, enable, load and the prescaler modes.

// File: rtl/stopwatch_pkg.sv
package stopwatch_pkg;

    localparam int DIGIT_W = 4;
    localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;

    typedef enum logic [1:0] {
        PM_HOLD     = 2'b00,
        PM_DOWN     = 2'b01,
        PM_DOWN_ALT = 2'b10,
        PM_RELOAD   = 2'b11
    } presc_mode_e;

    typedef struct packed {
        logic        show_lap;
        logic        grab_lap;
        logic        clr_digits;
        logic        en_digits;
        presc_mode_e mode;
    } ctrl_t;

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
    import stopwatch_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int RELOAD = 9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  presc_mode_e mode,
    output logic        tick
);

    localparam logic [CNT_W-1:0] RELOAD_V = CNT_W'(RELOAD);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } presc_state_t;

    presc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (mode)
            PM_HOLD: st_d.cnt = st_q.cnt;
            PM_DOWN, PM_DOWN_ALT: begin
                if (st_q.cnt == '0) begin
                    st_d.cnt = RELOAD_V;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            PM_RELOAD: st_d.cnt = RELOAD_V;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = (st_q.cnt == '0);

endmodule

// File: rtl/bcd_counter_chain.sv
module bcd_counter_chain
    import stopwatch_pkg::*;
#(
    parameter int NDIGITS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         en,
    output logic [NDIGITS*DIGIT_W-1:0]   value
);

    typedef struct packed {
        logic [NDIGITS-1:0][DIGIT_W-1:0] dig;
    } chain_state_t;

    chain_state_t st_d, st_q;
    logic [NDIGITS-1:0] adv;

    assign adv[0] = en;

    generate
        for (genvar g = 1; g < NDIGITS; g++) begin : g_carry
            assign adv[g] = adv[g-1] && (st_q.dig[g-1] == DIGIT_MAX);
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.dig = '0;
        end else begin
            for (int i = 0; i < NDIGITS; i++) begin
                if (adv[i]) begin
                    if (st_q.dig[i] == DIGIT_MAX) begin
                        st_d.dig[i] = '0;
                    end else begin
                        st_d.dig[i] = st_q.dig[i] + DIGIT_W'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.dig;

endmodule

// File: rtl/lap_select.sv
module lap_select #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         grab,
    input  logic         show_lap,
    input  logic [W-1:0] live,
    output logic [W-1:0] lap,
    output logic [W-1:0] shown
);

    typedef struct packed {
        logic [W-1:0] snap;
    } lap_state_t;

    lap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (grab) begin
            st_d.snap = live;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lap   = st_q.snap;
    assign shown = show_lap ? st_q.snap : live;

endmodule

// File: rtl/stopwatch_datapath.sv
module stopwatch_datapath
    import stopwatch_pkg::*;
#(
    parameter int CLK_HZ  = 100_000_000,
    parameter int NDIGITS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [5:0]                 ctrl,
    output logic                       tenth,
    output logic [NDIGITS*DIGIT_W-1:0] disp
);

    localparam int RELOAD = CLK_HZ / 10 - 1;
    localparam int CNT_W  = (RELOAD > 1) ? $clog2(RELOAD + 1) : 1;
    localparam int DISP_W = NDIGITS * DIGIT_W;

    ctrl_t cw;
    logic [DISP_W-1:0] live_w;
    logic [DISP_W-1:0] lap_w;

    assign cw = ctrl_t'(ctrl);

    tick_prescaler #(
        .CNT_W  (CNT_W),
        .RELOAD (RELOAD)
    ) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (cw.mode),
        .tick  (tenth)
    );

    bcd_counter_chain #(
        .NDIGITS (NDIGITS)
    ) u_digits (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cw.clr_digits),
        .en    (cw.en_digits),
        .value (live_w)
    );

    lap_select #(
        .W (DISP_W)
    ) u_lap (
        .clk      (clk),
        .rst_n    (rst_n),
        .grab     (cw.grab_lap),
        .show_lap (cw.show_lap),
        .live     (live_w),
        .lap      (lap_w),
        .shown    (disp)
    );

endmodule

// File: rtl/stopwatch_datapath_chk.sv
module stopwatch_datapath_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [5:0]    ctrl,
    input logic          tenth,
    input logic [DW-1:0] disp,
    input logic [DW-1:0] live,
    input logic [DW-1:0] lap
);

    // R1: a reset edge leaves everything at zero
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (live == '0) && (lap == '0) && tenth);

    // R3: hold mode freezes the prescaler
    assert_hold_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[1:0] == 2'b00) |=> $stable(tenth));

    // R4: reload leaves a nonzero count
    assert_reload_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[1:0] == 2'b11) |=> !tenth);

    // R5: while counting, tenth lasts a single cycle
    assert_tenth_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tenth && (ctrl[1:0] == 2'b01 || ctrl[1:0] == 2'b10)) |=> !tenth);

    // R6: enabled tenths digit steps by one below nine
    assert_tenths_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[2] && !ctrl[3] && live[3:0] != 4'd9) |=>
            live[3:0] == $past(live[3:0]) + 4'd1);

    // R6: no enable, no clear -> digits hold
    assert_digits_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[2] && !ctrl[3]) |=> $stable(live));

    // R8: clear wins over enable
    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[3] |=> (live == '0));

    // R9: load captures the previous live value
    assert_lap_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[4] |=> (lap == $past(live)));

    // R9: lap holds without load
    assert_lap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[4] |=> $stable(lap));

    // R10: lap view stays frozen while no load occurs
    assert_lap_view_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[5] && !ctrl[4]) ##1 ctrl[5] |-> $stable(disp));

endmodule

bind stopwatch_datapath stopwatch_datapath_chk #(
    .DW (DISP_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ctrl  (ctrl),
    .tenth (tenth),
    .disp  (disp),
    .live  (live_w),
    .lap   (lap_w)
);

// File: tb/stopwatch_datapath_tb.sv
module stopwatch_datapath_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 60;
    localparam int RELOAD     = CLK_HZ / 10 - 1;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  ctrl = 6'd0;
    logic        tenth;
    logic [15:0] disp;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    int m_presc = 0;
    int m_count = 0;
    int m_lap   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stopwatch_datapath #(
        .CLK_HZ  (CLK_HZ),
        .NDIGITS (4)
    ) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .ctrl  (ctrl),
        .tenth (tenth),
        .disp  (disp)
    );

    function automatic logic [15:0] to_bcd(input int v);
        logic [15:0] r;
        int t;
        t = v;
        for (int i = 0; i < 4; i++) begin
            r[i*4 +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic int next_presc(input int p, input logic [1:0] m);
        case (m)
            2'b00:   return p;
            2'b11:   return RELOAD;
            default: return (p == 0) ? RELOAD : p - 1;
        endcase
    endfunction

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // one cycle: drive, compare the current state, advance the model
    task automatic step(input logic [5:0] c, input logic r, input string tag);
        logic        exp_t;
        logic [15:0] exp_d;
        @(negedge clk);
        ctrl  = c;
        rst_n = r;
        #1;
        exp_t = (m_presc == 0);
        exp_d = c[5] ? to_bcd(m_lap) : to_bcd(m_count);
        n_checks++;
        if (tenth !== exp_t) begin
            n_fail++;
            $display("FAIL %s tenth: actual %b expected %b", tag, tenth, exp_t);
        end
        n_checks++;
        if (disp !== exp_d) begin
            n_fail++;
            $display("FAIL %s disp: actual %h expected %h", tag, disp, exp_d);
        end
        if (!r) begin
            m_presc = 0;
            m_count = 0;
            m_lap   = 0;
        end else begin
            if (c[4]) m_lap = m_count;
            if (c[3]) m_count = 0;
            else if (c[2]) m_count = (m_count + 1) % 10000;
            m_presc = next_presc(m_presc, c[1:0]);
        end
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        ctrl  = 6'd0;
        repeat (3) @(posedge clk);

        // R1: reset state under both display sources
        step(6'b000000, 1'b0, "R1");
        step(6'b100000, 1'b0, "R1");
        step(6'b000000, 1'b1, "R1");

        // R2 / R5: both down codes, several periods
        for (int i = 0; i < 3 * (RELOAD + 1); i++) step(6'b000001, 1'b1, "R2");
        for (int i = 0; i < 2 * (RELOAD + 1); i++) step(6'b000010, 1'b1, "R5");

        // R3: hold mid-count and at zero
        step(6'b000001, 1'b1, "R3");
        for (int i = 0; i < 4; i++) step(6'b000000, 1'b1, "R3");
        while (m_presc != 0) step(6'b000001, 1'b1, "R3");
        for (int i = 0; i < 4; i++) step(6'b000000, 1'b1, "R3");

        // R4: reload then count down from the top
        step(6'b000011, 1'b1, "R4");
        for (int i = 0; i < RELOAD + 2; i++) step(6'b000001, 1'b1, "R4");

        // R6: enabled tenths stepping through a wrap, then hold
        for (int i = 0; i < 25; i++) step(6'b000100, 1'b1, "R6");
        for (int i = 0; i < 5; i++) step(6'b000000, 1'b1, "R6");

        // R8: clear with and without enable
        step(6'b001100, 1'b1, "R8");
        for (int i = 0; i < 7; i++) step(6'b000100, 1'b1, "R8");
        step(6'b001000, 1'b1, "R8");
        step(6'b000000, 1'b1, "R8");

        // R7: full run past 9:99.9 back to zero
        for (int i = 0; i < 10005; i++) step(6'b000100, 1'b1, "R7");

        // R9 / R10: capture, freeze view, keep live count running
        step(6'b010100, 1'b1, "R9");
        for (int i = 0; i < 30; i++) step(6'b100100, 1'b1, "R10");
        step(6'b000000, 1'b1, "R10");
        step(6'b110000, 1'b1, "R9");
        step(6'b100000, 1'b1, "R9");

        // mixed random traffic with occasional resets
        for (int i = 0; i < 4000; i++) begin
            logic [5:0] c;
            logic       r;
            c = 6'($urandom);
            if (($urandom % 4) != 0) c[3] = 1'b0;
            r = (($urandom % 97) != 0);
            step(c, r, "mix");
        end

        done = 1;
        report();
    end

endmodule